// File: doc/BRIEF.md
# Descriptor Ring DMA Engine

This block moves Ethernet frames between memory and a pair of word streams by walking two rings of descriptors that live in system memory: one ring for frames leaving the device, one for frames arriving. Each descriptor is four 32-bit words: a status word, a control word holding flags and a byte count, a buffer address, and a spare link word that the engine does not use. The top bit of the status word tells who holds the entry. While it is set the engine may use the entry. Once the engine has finished with the entry it clears that bit, and the host can then take the entry back.

Both engines share one memory request port, and a small arbiter sits between them. The transmit side reads a descriptor, streams the buffer out word by word, and then writes a clean status word. The receive side fills a buffer from the incoming stream and writes a status word that carries the frame length and the error flag. Each ring has its own enable and its own 3-bit process state. A poll strobe wakes a transmit side that has stopped on an entry the host still holds. The receive side retries on a timer instead.

Top module: `dring_engine`

## Requirements
- R1: After reset, `tx_state` and `rx_state` read 0 (stopped), `mem_req`, `tx_valid` and `rx_ready` are low. The state codes are: 0 stopped, 1 fetching a descriptor, 2 moving data, 3 writing status, 4 suspended.
- R2: When transmit is enabled, the engine reads the descriptor at its current entry, found at byte offsets 0, 4 and 8. If bit 31 of the status word is set, the engine presents the buffer words in address order on `tx_data`, one word per `tx_valid`/`tx_ready` handshake. The number of words is ceil(len/4), where len is bits [LEN_W-1:0] of the control word, and `tx_last` is high on the final word. `tx_valid` and `tx_data` hold steady while `tx_ready` is low.
- R3: After the last transmit word, the engine writes 0x00000000 to the status word of that entry. This clears the owner bit 31 and the error bit 15.
- R4: A transmit status read with bit 31 clear puts the transmit side in state 4. It makes no memory request until `tx_poll` is pulsed, and it then reads the same entry again.
- R5: After an entry whose control bit 25 is set, the next entry is the ring base. Otherwise the next entry is the current address plus 16.
- R6: The receive side stores the incoming words into consecutive buffer words. On the word marked `rx_last` it writes status as follows: bits 31:16 = 4 × received words (bit 31 therefore 0), bit 8 = 1, and bit 15 = `rx_err` of the last word. All other bits are 0.
- R7: Receive words that would end past the buffer size (bits [LEN_W-1:0] of the control word, in bytes) are not written to memory. The length still counts them, and bit 15 of the written status is set.
- R8: A receive status read with bit 31 clear puts the receive side in state 4. It fetches the same entry again every RX_RETRY cycles until it finds the owner bit set, with no host action needed.
- R9: When both sides request memory in a cycle where the port is free, receive is served first. A request keeps `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`.
- R10: Clearing an enable stops that side (state 0) at its next descriptor boundary, or at once while suspended. Enabling it again restarts at its ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmit run enable |
| rx_enable | input | 1 | Receive run enable |
| tx_poll | input | 1 | One-cycle strobe that wakes a suspended transmit side |
| tx_ring_base | input | 32 | Byte address of transmit ring entry 0 |
| rx_ring_base | input | 32 | Byte address of receive ring entry 0 |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion pulse; read data valid with it |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 32 | Outgoing frame word |
| tx_valid | output | 1 | Outgoing word valid |
| tx_last | output | 1 | Final word of the frame |
| tx_ready | input | 1 | Sink accepts the word |
| rx_data | input | 32 | Incoming frame word |
| rx_valid | input | 1 | Incoming word valid |
| rx_last | input | 1 | Final word of the frame |
| rx_err | input | 1 | Frame error, sampled with the last word |
| rx_ready | output | 1 | Engine accepts an incoming word |
| tx_state | output | 3 | Transmit process state |
| rx_state | output | 3 | Receive process state |

## Verification
The two functions that can fall in the same cycle are the receive side's buffer and status writes and the transmit side's descriptor and buffer reads, because both contend for the single memory port. The bench provokes the clash by stopping transmit, re-arming an entry at the transmit ring base and then enabling transmit in the same cycle that a receive frame starts to arrive. The arbitration order is judged by a property that requires the receive address on the port whenever both request while the port is free. Both results are then judged independently: the transmit words must match the bench's expected queue, and the receive buffer and status words must be correct in memory.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int WORD_W    = 32;
  localparam int DESC_STEP = 16;
  localparam int OWN_POS   = 31;
  localparam int WRAP_POS  = 25;
  localparam int ERR_POS   = 15;
  localparam int LAST_POS  = 8;

  typedef enum logic [2:0] {
    PS_STOP  = 3'd0,
    PS_FETCH = 3'd1,
    PS_MOVE  = 3'd2,
    PS_CLOSE = 3'd3,
    PS_SUSP  = 3'd4
  } proc_state_e;

  // address of the entry that follows cur
  function automatic logic [WORD_W-1:0] next_entry(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] base,
                                                   input logic wrap);
    return wrap ? base : WORD_W'(cur + WORD_W'(DESC_STEP));
  endfunction

  // number of 32-bit words that carry nbytes
  function automatic logic [15:0] word_count(input logic [15:0] nbytes);
    logic [16:0] t;
    t = {1'b0, nbytes} + 17'd3;
    return 16'(t[16:2]);
  endfunction

  // true when word idx ends inside a buffer of size bytes
  function automatic logic word_fits(input logic [15:0] idx, input logic [15:0] size);
    logic [17:0] end_b;
    end_b = {idx, 2'b00} + 18'd4;
    return end_b <= {2'b00, size};
  endfunction

  // receive status word: length in 30:16, error, last-descriptor mark
  function automatic logic [WORD_W-1:0] rx_close_word(input logic [15:0] nwords,
                                                      input logic err);
    logic [15:0] nb;
    nb = {1'b0, nwords[12:0], 2'b00};
    return {nb, err, 6'b0, 1'b1, 8'b0};
  endfunction

  // byte offset of buffer word idx
  function automatic logic [WORD_W-1:0] word_offset(input logic [15:0] idx);
    return {16'b0, idx[13:0], 2'b00};
  endfunction
endpackage

// File: rtl/dre_tx.sv
module dre_tx
  import dre_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              poll,
  input  logic [WORD_W-1:0] base,
  output logic              req,
  output logic              we,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  input  logic              ack,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready,
  output logic [2:0]        state,
  output logic              wb
);
  typedef enum logic [2:0] {T_STOP, T_FST, T_FCT, T_FBA, T_RD, T_OUT, T_WB, T_SUSP} tst_e;

  tst_e              st;
  logic [WORD_W-1:0] ptr;
  logic [WORD_W-1:0] buf_a;
  logic [WORD_W-1:0] data_q;
  logic [15:0]       idx;
  logic [15:0]       nwords;
  logic              wrap_q;
  logic              final_word;

  assign final_word = (idx == 16'(nwords - 16'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_STOP;
      ptr    <= '0;
      buf_a  <= '0;
      data_q <= '0;
      idx    <= '0;
      nwords <= '0;
      wrap_q <= 1'b0;
    end else begin
      case (st)
        T_STOP: if (en) begin
          ptr <= base;
          st  <= T_FST;
        end
        T_FST: if (ack) st <= rdata[OWN_POS] ? T_FCT : T_SUSP;
        T_FCT: if (ack) begin
          wrap_q <= rdata[WRAP_POS];
          nwords <= word_count(16'(rdata[LEN_W-1:0]));
          st     <= T_FBA;
        end
        T_FBA: if (ack) begin
          buf_a <= rdata;
          idx   <= '0;
          st    <= (nwords == 16'd0) ? T_WB : T_RD;
        end
        T_RD: if (ack) begin
          data_q <= rdata;
          st     <= T_OUT;
        end
        T_OUT: if (out_ready) begin
          if (final_word) st <= T_WB;
          else begin
            idx <= 16'(idx + 16'd1);
            st  <= T_RD;
          end
        end
        T_WB: if (ack) begin
          ptr <= next_entry(ptr, base, wrap_q);
          st  <= en ? T_FST : T_STOP;
        end
        T_SUSP: begin
          if (!en) st <= T_STOP;
          else if (poll) st <= T_FST;
        end
        default: st <= T_STOP;
      endcase
    end
  end

  always_comb begin
    req  = 1'b0;
    addr = ptr;
    case (st)
      T_FST: req = 1'b1;
      T_FCT: begin req = 1'b1; addr = WORD_W'(ptr + 32'd4); end
      T_FBA: begin req = 1'b1; addr = WORD_W'(ptr + 32'd8); end
      T_RD:  begin req = 1'b1; addr = WORD_W'(buf_a + word_offset(idx)); end
      T_WB:  req = 1'b1;
      default: ;
    endcase
  end

  assign we        = (st == T_WB);
  assign wb        = (st == T_WB);
  assign wdata     = '0;
  assign out_valid = (st == T_OUT);
  assign out_data  = data_q;
  assign out_last  = (st == T_OUT) && final_word;

  always_comb begin
    case (st)
      T_STOP:               state = PS_STOP;
      T_FST, T_FCT, T_FBA:  state = PS_FETCH;
      T_RD, T_OUT:          state = PS_MOVE;
      T_WB:                 state = PS_CLOSE;
      default:              state = PS_SUSP;
    endcase
  end
endmodule

// File: rtl/dre_rx.sv
module dre_rx
  import dre_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int RX_RETRY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] base,
  output logic              req,
  output logic              we,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  input  logic              ack,
  input  logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic [2:0]        state,
  output logic              wb
);
  localparam int RT_W = (RX_RETRY > 1) ? $clog2(RX_RETRY) : 1;
  localparam logic [RT_W-1:0] RT_END = RT_W'(RX_RETRY - 1);

  typedef enum logic [2:0] {R_STOP, R_FST, R_FCT, R_FBA, R_RECV, R_WR, R_CLOSE, R_SUSP} rst_e;

  rst_e              st;
  logic [WORD_W-1:0] ptr;
  logic [WORD_W-1:0] buf_a;
  logic [WORD_W-1:0] wr_addr;
  logic [WORD_W-1:0] word_q;
  logic [15:0]       size_q;
  logic [15:0]       idx;
  logic              wrap_q;
  logic              last_q;
  logic              err_q;
  logic              ovf_q;
  logic [RT_W-1:0]   retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= R_STOP;
      ptr     <= '0;
      buf_a   <= '0;
      wr_addr <= '0;
      word_q  <= '0;
      size_q  <= '0;
      idx     <= '0;
      wrap_q  <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
      retry   <= '0;
    end else begin
      case (st)
        R_STOP: if (en) begin
          ptr <= base;
          st  <= R_FST;
        end
        R_FST: if (ack) begin
          retry <= '0;
          st    <= rdata[OWN_POS] ? R_FCT : R_SUSP;
        end
        R_FCT: if (ack) begin
          wrap_q <= rdata[WRAP_POS];
          size_q <= 16'(rdata[LEN_W-1:0]);
          st     <= R_FBA;
        end
        R_FBA: if (ack) begin
          buf_a  <= rdata;
          idx    <= '0;
          err_q  <= 1'b0;
          ovf_q  <= 1'b0;
          last_q <= 1'b0;
          st     <= R_RECV;
        end
        R_RECV: if (in_valid) begin
          idx    <= 16'(idx + 16'd1);
          last_q <= in_last;
          if (in_last) err_q <= in_err;
          if (word_fits(idx, size_q)) begin
            wr_addr <= WORD_W'(buf_a + word_offset(idx));
            word_q  <= in_data;
            st      <= R_WR;
          end else begin
            ovf_q <= 1'b1;
            if (in_last) st <= R_CLOSE;
          end
        end
        R_WR: if (ack) st <= last_q ? R_CLOSE : R_RECV;
        R_CLOSE: if (ack) begin
          ptr <= next_entry(ptr, base, wrap_q);
          st  <= en ? R_FST : R_STOP;
        end
        R_SUSP: begin
          if (!en) st <= R_STOP;
          else if (retry == RT_END) begin
            retry <= '0;
            st    <= R_FST;
          end else retry <= RT_W'(retry + 1'b1);
        end
        default: st <= R_STOP;
      endcase
    end
  end

  always_comb begin
    req   = 1'b0;
    addr  = ptr;
    wdata = word_q;
    case (st)
      R_FST:   req = 1'b1;
      R_FCT:   begin req = 1'b1; addr = WORD_W'(ptr + 32'd4); end
      R_FBA:   begin req = 1'b1; addr = WORD_W'(ptr + 32'd8); end
      R_WR:    begin req = 1'b1; addr = wr_addr; end
      R_CLOSE: begin req = 1'b1; wdata = rx_close_word(idx, err_q | ovf_q); end
      default: ;
    endcase
  end

  assign we       = (st == R_WR) || (st == R_CLOSE);
  assign wb       = (st == R_CLOSE);
  assign in_ready = (st == R_RECV);

  always_comb begin
    case (st)
      R_STOP:              state = PS_STOP;
      R_FST, R_FCT, R_FBA: state = PS_FETCH;
      R_RECV, R_WR:        state = PS_MOVE;
      R_CLOSE:             state = PS_CLOSE;
      default:             state = PS_SUSP;
    endcase
  end
endmodule

// File: rtl/dre_arb.sv
module dre_arb
  import dre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              tx_we,
  input  logic [WORD_W-1:0] tx_addr,
  input  logic [WORD_W-1:0] tx_wdata,
  output logic              tx_ack,
  input  logic              rx_req,
  input  logic              rx_we,
  input  logic [WORD_W-1:0] rx_addr,
  input  logic [WORD_W-1:0] rx_wdata,
  output logic              rx_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              gnt_tx,
  output logic              gnt_rx
);
  logic owner_rx;
  logic pick_rx;

  // a held grant keeps its owner; a free port favours receive
  assign pick_rx   = busy ? owner_rx : rx_req;
  assign mem_req   = pick_rx ? rx_req   : tx_req;
  assign mem_we    = pick_rx ? rx_we    : tx_we;
  assign mem_addr  = pick_rx ? rx_addr  : tx_addr;
  assign mem_wdata = pick_rx ? rx_wdata : tx_wdata;
  assign gnt_rx    = pick_rx && rx_req;
  assign gnt_tx    = !pick_rx && tx_req;
  assign rx_ack    = mem_ack && pick_rx;
  assign tx_ack    = mem_ack && !pick_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      owner_rx <= 1'b0;
    end else if (mem_ack) begin
      busy <= 1'b0;
    end else if (mem_req && !busy) begin
      busy     <= 1'b1;
      owner_rx <= pick_rx;
    end
  end
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dre_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int RX_RETRY = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_enable,
  input  logic        rx_enable,
  input  logic        tx_poll,
  input  logic [31:0] tx_ring_base,
  input  logic [31:0] rx_ring_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [31:0] tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic [31:0] rx_data,
  input  logic        rx_valid,
  input  logic        rx_last,
  input  logic        rx_err,
  output logic        rx_ready,
  output logic [2:0]  tx_state,
  output logic [2:0]  rx_state
);
  logic              tx_req, tx_we, tx_ack, tx_wb;
  logic [WORD_W-1:0] tx_addr, tx_wdata;
  logic              rx_req, rx_we, rx_ack, rx_wb;
  logic [WORD_W-1:0] rx_addr, rx_wdata;
  logic              arb_busy, gnt_tx, gnt_rx;

  dre_tx #(.LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_enable), .poll(tx_poll), .base(tx_ring_base),
    .req(tx_req), .we(tx_we), .addr(tx_addr), .wdata(tx_wdata),
    .ack(tx_ack), .rdata(mem_rdata),
    .out_data(tx_data), .out_valid(tx_valid), .out_last(tx_last), .out_ready(tx_ready),
    .state(tx_state), .wb(tx_wb)
  );

  dre_rx #(.LEN_W(LEN_W), .RX_RETRY(RX_RETRY)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_enable), .base(rx_ring_base),
    .req(rx_req), .we(rx_we), .addr(rx_addr), .wdata(rx_wdata),
    .ack(rx_ack), .rdata(mem_rdata),
    .in_data(rx_data), .in_valid(rx_valid), .in_last(rx_last), .in_err(rx_err),
    .in_ready(rx_ready), .state(rx_state), .wb(rx_wb)
  );

  dre_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_ack(tx_ack),
    .rx_req(rx_req), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_ack(rx_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .busy(arb_busy), .gnt_tx(gnt_tx), .gnt_rx(gnt_rx)
  );
endmodule

// File: rtl/dre_checker.sv
module dre_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        tx_last,
  input logic        tx_req,
  input logic        rx_req,
  input logic [31:0] rx_addr,
  input logic        arb_busy,
  input logic        gnt_tx,
  input logic        gnt_rx,
  input logic        tx_wb,
  input logic        rx_wb
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9

  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_busy && rx_req && tx_req |-> gnt_rx && !gnt_tx && mem_addr == rx_addr); // R9

  AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R2

  AST_TX_CLOSE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_tx && tx_wb |-> mem_we && mem_wdata == 32'h0); // R3

  AST_RX_CLOSE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_rx && rx_wb |-> mem_we && !mem_wdata[31] && mem_wdata[8]); // R6
endmodule

bind dring_engine dre_checker i_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .tx_req(tx_req), .rx_req(rx_req), .rx_addr(rx_addr),
  .arb_busy(arb_busy), .gnt_tx(gnt_tx), .gnt_rx(gnt_rx),
  .tx_wb(tx_wb), .rx_wb(rx_wb)
);

// File: tb/test_dring_engine.sv
module test_dring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [31:0] TXB = 32'h100;
  localparam logic [31:0] RXB = 32'h200;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h0200_0000;
  localparam logic [31:0] SEG = 32'h6000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_enable = 1'b0, rx_enable = 1'b0, tx_poll = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] tx_data;
  logic        tx_valid, tx_last, tx_ready = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, rx_ready;
  logic [2:0]  tx_state, rx_state;

  int checks = 0;
  int fails  = 0;
  int tx_seen = 0;
  logic [31:0] mem [0:511];
  logic [31:0] exp_data[$];
  logic        exp_last[$];

  dring_engine i_dring_engine (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .tx_poll(tx_poll), .tx_ring_base(TXB), .rx_ring_base(RXB),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready), .tx_state(tx_state), .rx_state(rx_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[10:2]];
        if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wi(input logic [31:0] a);
    return int'(a >> 2);
  endfunction

  task automatic put_desc(input logic [31:0] at, input logic [31:0] st,
                          input logic [31:0] ctl, input logic [31:0] bufa);
    mem[wi(at)] = st; mem[wi(at)+1] = ctl; mem[wi(at)+2] = bufa; mem[wi(at)+3] = 32'h0;
  endtask

  // fill a transmit buffer and queue the words the sink must see
  task automatic tx_frame(input logic [31:0] bufa, input int nbytes, input logic [31:0] seed);
    int nw;
    nw = (nbytes + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      mem[wi(bufa)+i] = seed + i;
      exp_data.push_back(seed + i);
      exp_last.push_back(i == nw - 1);
    end
  endtask

  task automatic rx_word(input logic [31:0] d, input logic last, input logic err);
    logic hs;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
    hs = 1'b0;
    while (!hs) begin
      hs = rx_ready;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic wait_tx(input logic [2:0] s);
    int n = 0;
    while (tx_state !== s && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rx(input logic [2:0] s);
    int n = 0;
    while (rx_state !== s && n < 3000) begin @(negedge clk); n++; end
  endtask

  // sink: sets ready, then compares any word accepted at the next edge
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (cyc % 3) != 0;
      if (rst_n && tx_valid && tx_ready) begin
        tx_seen++;
        if (exp_data.size() == 0) chk("R2 unexpected tx word", tx_data, 32'hxxxx_xxxx);
        else begin
          chk("R2 tx word", tx_data, exp_data.pop_front());
          chk("R2 tx last", {31'b0, tx_last}, {31'b0, exp_last.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int quiet;
    for (int i = 0; i < 512; i++) mem[i] = 32'hDEAD_0000 + i;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_state", {29'b0, tx_state}, 32'd0);
    chk("R1 rx_state", {29'b0, rx_state}, 32'd0);
    chk("R1 idle port", {29'b0, mem_req, tx_valid, rx_ready}, 32'd0);

    // transmit: two entries, second wraps to base
    put_desc(TXB,        OWN, SEG | 32'd10,       32'h300);
    put_desc(TXB + 32'h10, OWN, SEG | EOR | 32'd4, 32'h340);
    tx_frame(32'h300, 10, 32'h3000_0000);
    tx_frame(32'h340, 4,  32'h3400_0000);
    tx_enable = 1'b1;
    wait_tx(3'd4);
    chk("R4 suspended on cleared owner", {29'b0, tx_state}, 32'd4);
    chk("R2 words streamed", tx_seen, 32'd4);
    chk("R3 status cleared entry 0", mem[wi(TXB)], 32'h0);
    chk("R3 status cleared entry 1", mem[wi(TXB)+4], 32'h0);

    // re-arm base entry; nothing moves until poll
    put_desc(TXB, OWN, SEG | 32'd8, 32'h360);
    tx_frame(32'h360, 8, 32'h3600_0000);
    quiet = 0;
    repeat (30) begin @(negedge clk); if (mem_req) quiet++; end
    chk("R4 no request while suspended", quiet, 32'd0);
    chk("R4 no stream while suspended", tx_seen, 32'd4);
    tx_poll = 1'b1; @(negedge clk); tx_poll = 1'b0;
    wait_tx(3'd2);
    wait_tx(3'd4);
    chk("R5 wrap fetched base entry", tx_seen, 32'd6);
    chk("R3 base entry closed", mem[wi(TXB)], 32'h0);

    // receive
    put_desc(RXB,        OWN, 32'd64,       32'h400);
    put_desc(RXB + 32'h10, OWN, EOR | 32'd8, 32'h480);
    rx_enable = 1'b1;
    rx_word(32'hA000_0001, 1'b0, 1'b0);
    rx_word(32'hA000_0002, 1'b0, 1'b0);
    rx_word(32'hA000_0003, 1'b1, 1'b0);
    rx_word(32'hB000_0001, 1'b0, 1'b0);
    rx_word(32'hB000_0002, 1'b0, 1'b0);
    rx_word(32'hB000_0003, 1'b0, 1'b0);
    rx_word(32'hB000_0004, 1'b1, 1'b0);
    wait_rx(3'd4);
    chk("R8 rx suspended", {29'b0, rx_state}, 32'd4);
    chk("R6 frame A word 0", mem[wi(32'h400)], 32'hA000_0001);
    chk("R6 frame A word 2", mem[wi(32'h408)], 32'hA000_0003);
    chk("R6 frame A status", mem[wi(RXB)], 32'h000C_0100);
    chk("R7 frame B word 1 kept", mem[wi(32'h484)], 32'hB000_0002);
    chk("R7 frame B overflow not written", mem[wi(32'h488)], 32'hDEAD_0000 + 32'(wi(32'h488)));
    chk("R7 frame B status", mem[wi(RXB)+4], 32'h0010_8100);

    mem[wi(RXB)] = OWN;
    rx_word(32'hC000_0001, 1'b1, 1'b1);
    wait_rx(3'd4);
    chk("R8 resumed after retry", mem[wi(32'h400)], 32'hC000_0001);
    chk("R6 error frame status", mem[wi(RXB)], 32'h0004_8100);

    // stop, then restart concurrently with a receive frame
    tx_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 tx stopped", {29'b0, tx_state}, 32'd0);
    put_desc(TXB, OWN, SEG | 32'd12, 32'h3A0);
    tx_frame(32'h3A0, 12, 32'h3A00_0000);
    put_desc(RXB + 32'h10, OWN, EOR | 32'd8, 32'h480);
    fork
      begin @(negedge clk); tx_enable = 1'b1; end
      begin
        rx_word(32'hD000_0001, 1'b0, 1'b0);
        rx_word(32'hD000_0002, 1'b1, 1'b0);
      end
    join
    wait_tx(3'd4);
    wait_rx(3'd4);
    chk("R10 restart from base streamed", tx_seen, 32'd9);
    chk("R9 rx words under contention", mem[wi(32'h484)], 32'hD000_0002);
    chk("R9 rx status under contention", mem[wi(RXB)+4], 32'h0008_0100);
    chk("R3 tx close under contention", mem[wi(TXB)], 32'h0);
    chk("R2 expected queue drained", exp_data.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule